// File: doc/BRIEF.md
# Dual-Function PCI Request Arbiter

This block lets two internal bus masters, a video DMA engine and an audio DMA engine, share a single PCI request/grant pair. It merges the two internal requests into the external active-low REQ# line. It hands the external GNT# to exactly one of the two engines as a combinational internal grant. It also watches FRAME# and IRDY# to learn when a transaction starts and when the bus returns to idle.

The audio engine has priority: if it is requesting while GNT# is asserted, it gets the grant, even if its request came after the video one. With nothing requesting, the grant parks on video. Once a transaction has begun, the grant is pinned to the engine that started it until the bus is idle again.

A compatibility input selects a stricter mode. In that mode, the arbiter freezes its choice as soon as GNT# arrives. From that point only the chosen engine's request reaches REQ#, so REQ# falls together with that engine's request when FRAME# starts. The freeze ends when the transaction finishes.

Top module: `dual_master_req_arb`

## Requirements
- R1: With `compat_en` low, `pci_req_n` is low exactly when `vid_req` or `aud_req` (active high) is high, in the same cycle.
- R2: While `pci_gnt_n` is high, both `vid_gnt` and `aud_gnt` are low. While `pci_gnt_n` is low, exactly one of them is high, in the same cycle.
- R3: With no request and no transaction in progress, a low `pci_gnt_n` raises `vid_gnt` (parking on video).
- R4: Outside a transaction, and with no frozen decision, `aud_gnt` is chosen whenever `aud_req` is high while `pci_gnt_n` is low, whatever the state of `vid_req`.
- R5: A transaction starts when `pci_frame_n` goes low in the cycle after a cycle with `pci_gnt_n` low. From then until a cycle with `pci_frame_n` and `pci_irdy_n` both high, the grant stays with the engine granted in that earlier cycle, whatever the requests do.
- R6: With `compat_en` high and no frozen decision, `pci_req_n` is the inverted OR of both requests while `pci_gnt_n` is high.
- R7: With `compat_en` high, the first cycle with `pci_gnt_n` low freezes the engine chosen in that cycle. While frozen, only that engine's request drives `pci_req_n`, and a low `pci_gnt_n` keeps steering to it even if the other engine's request changes.
- R8: In compatibility mode, when `pci_frame_n` goes low and the frozen engine drops its request in that cycle, `pci_req_n` goes high in the same cycle, even if the other engine is requesting.
- R9: The freeze of a started transaction lasts through the first idle cycle (both `pci_frame_n` and `pci_irdy_n` high). From the next cycle on, `pci_req_n` is again the OR of both requests.
- R10: If the grant is withdrawn (`pci_gnt_n` high) with `pci_frame_n` high and no transaction started, the freeze is released at the end of that cycle.
- R11: While `rst_n` is low (synchronous), the freeze and ownership state clear, so a low `pci_gnt_n` raises `vid_gnt`. With `pci_gnt_n` high and no requests, the outputs are `pci_req_n` high and both grants low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| compat_en | input | 1 | Selects the decision-freezing compatibility mode |
| vid_req | input | 1 | Video engine bus request, active high |
| aud_req | input | 1 | Audio engine bus request, active high |
| pci_gnt_n | input | 1 | External bus grant, active low |
| pci_frame_n | input | 1 | Bus FRAME#, active low |
| pci_irdy_n | input | 1 | Bus IRDY#, active low |
| pci_req_n | output | 1 | External bus request, active low |
| vid_gnt | output | 1 | Grant to video engine, active high |
| aud_gnt | output | 1 | Grant to audio engine, active high |

## Verification
The assertions assume that FRAME# and IRDY# are driven only by transactions this block's engines start. In particular, they assume a low FRAME# never follows a grant cycle unless it belongs to the granted engine. The non-preemption checks also rely on FRAME# going low only in the cycle right after a grant. The stimulus follows these rules: it asserts FRAME# one cycle after GNT#, ends each transaction with a FRAME#-high/IRDY#-low phase and then a full idle cycle, and never drives FRAME# low without a preceding grant.

// File: rtl/dual_master_req_arb.sv
module dual_master_req_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic compat_en,
  input  logic vid_req,
  input  logic aud_req,
  input  logic pci_gnt_n,
  input  logic pci_frame_n,
  input  logic pci_irdy_n,
  output logic pci_req_n,
  output logic vid_gnt,
  output logic aud_gnt
);

  logic lock_v, lock_aud;
  logic own_v, own_aud;
  logic gnt_q, sel_q;

  logic gnt, bus_idle, own_pend, own_live, sel_aud, locking, lock_drop;

  assign gnt      = ~pci_gnt_n;
  assign bus_idle = pci_frame_n & pci_irdy_n;
  assign own_pend = ~own_v & gnt_q & ~pci_frame_n;
  assign own_live = own_v & ~bus_idle;

  assign sel_aud = own_live ? own_aud :
                   own_pend ? sel_q   :
                   lock_v   ? lock_aud : aud_req;

  assign locking = compat_en & (lock_v | gnt);

  assign pci_req_n = ~(locking ? (sel_aud ? aud_req : vid_req) : (aud_req | vid_req));
  assign vid_gnt   = gnt & ~sel_aud;
  assign aud_gnt   = gnt &  sel_aud;

  assign lock_drop = ~compat_en | (own_v ? bus_idle : (pci_frame_n & ~gnt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      gnt_q <= gnt;
      sel_q <= sel_aud;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v   <= 1'b0;
      own_aud <= 1'b0;
    end else if (own_v && bus_idle) begin
      own_v   <= 1'b0;
    end else if (own_pend) begin
      own_v   <= 1'b1;
      own_aud <= sel_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_v   <= 1'b0;
      lock_aud <= 1'b0;
    end else if (lock_v && lock_drop) begin
      lock_v   <= 1'b0;
    end else if (compat_en && gnt && !lock_v) begin
      lock_v   <= 1'b1;
      lock_aud <= sel_aud;
    end
  end

endmodule

// File: rtl/dual_master_req_arb_chk.sv
module dual_master_req_arb_chk (
  input logic clk,
  input logic rst_n,
  input logic compat_en,
  input logic vid_req,
  input logic aud_req,
  input logic pci_gnt_n,
  input logic pci_frame_n,
  input logic pci_irdy_n,
  input logic pci_req_n,
  input logic vid_gnt,
  input logic aud_gnt
);

  logic idle;
  assign idle = pci_frame_n & pci_irdy_n;

  p_or_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !compat_en |-> (pci_req_n == !(vid_req || aud_req)));

  p_gnt_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pci_gnt_n |-> (!vid_gnt && !aud_gnt));

  p_gnt_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_gnt_n |-> $countones({vid_gnt, aud_gnt}) == 1);

  p_audio_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pci_gnt_n && aud_req && !compat_en && $past(!compat_en) &&
     $past(pci_gnt_n) && idle && $past(idle)) |-> aud_gnt);

  p_no_preempt_vid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle) && $past(vid_gnt)) |-> !aud_gnt);

  p_no_preempt_aud_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && $past(!idle) && $past(aud_gnt)) |-> !vid_gnt);

  p_req_drop_vid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (compat_en && $past(compat_en) && $past(vid_gnt) && !pci_frame_n && !vid_req) |-> pci_req_n);

  p_req_drop_aud_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (compat_en && $past(compat_en) && $past(aud_gnt) && !pci_frame_n && !aud_req) |-> pci_req_n);

endmodule

bind dual_master_req_arb dual_master_req_arb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .compat_en(compat_en), .vid_req(vid_req), .aud_req(aud_req),
  .pci_gnt_n(pci_gnt_n), .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
  .pci_req_n(pci_req_n), .vid_gnt(vid_gnt), .aud_gnt(aud_gnt)
);

// File: tb/test_dual_master_req_arb.sv
module test_dual_master_req_arb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, compat_en, vid_req, aud_req, pci_gnt_n, pci_frame_n, pci_irdy_n;
  logic pci_req_n, vid_gnt, aud_gnt;

  typedef struct {
    logic  req_n;
    logic  vg;
    logic  ag;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_master_req_arb i_dual_master_req_arb (
    .clk(clk), .rst_n(rst_n), .compat_en(compat_en), .vid_req(vid_req), .aud_req(aud_req),
    .pci_gnt_n(pci_gnt_n), .pci_frame_n(pci_frame_n), .pci_irdy_n(pci_irdy_n),
    .pci_req_n(pci_req_n), .vid_gnt(vid_gnt), .aud_gnt(aud_gnt)
  );

  task automatic step(input logic rs, input logic c, input logic v, input logic a,
                      input logic gn, input logic fn, input logic irn,
                      input logic ern, input logic evg, input logic eag, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    rst_n = rs; compat_en = c; vid_req = v; aud_req = a;
    pci_gnt_n = gn; pci_frame_n = fn; pci_irdy_n = irn;
    e.req_n = ern; e.vg = evg; e.ag = eag; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (pci_req_n !== e.req_n || vid_gnt !== e.vg || aud_gnt !== e.ag) begin
        n_bad++;
        $display("FAIL %s: got req_n=%b vid_gnt=%b aud_gnt=%b, expected req_n=%b vid_gnt=%b aud_gnt=%b",
                 e.tag, pci_req_n, vid_gnt, aud_gnt, e.req_n, e.vg, e.ag);
      end
    end
  end

  initial begin
    rst_n = 0; compat_en = 0; vid_req = 0; aud_req = 0;
    pci_gnt_n = 1; pci_frame_n = 1; pci_irdy_n = 1;
    //   rst c v a gn fn irn  req_n vg ag
    step(0, 0,0,0, 1, 1,1,  1,0,0, "R11 reset idle");
    step(0, 0,0,0, 0, 1,1,  1,1,0, "R11 reset park");
    step(0, 0,0,0, 1, 1,1,  1,0,0, "R2 reset no grant");
    // normal mode
    step(1, 0,1,0, 1, 1,1,  0,0,0, "R1 video only");
    step(1, 0,0,1, 1, 1,1,  0,0,0, "R1 audio only");
    step(1, 0,0,0, 1, 1,1,  1,0,0, "R1 none");
    step(1, 0,0,0, 0, 1,1,  1,1,0, "R3 park video");
    step(1, 0,0,0, 1, 1,1,  1,0,0, "R2 grant off");
    step(1, 0,1,0, 1, 1,1,  0,0,0, "R1 video first");
    step(1, 0,1,1, 1, 1,1,  0,0,0, "R1 audio late");
    step(1, 0,1,1, 0, 1,1,  0,0,1, "R4 audio wins");
    step(1, 0,1,0, 0, 0,1,  0,0,1, "R5 frame start audio held");
    step(1, 0,1,0, 0, 0,0,  0,0,1, "R5 data audio held");
    step(1, 0,1,0, 0, 1,0,  0,0,1, "R5 last phase audio held");
    step(1, 0,1,0, 0, 1,1,  0,1,0, "R5 idle releases");
    step(1, 0,1,0, 0, 1,1,  0,1,0, "R3 video granted");
    step(1, 0,0,1, 0, 0,1,  0,1,0, "R5 no preempt by audio");
    step(1, 0,0,1, 0, 0,0,  0,1,0, "R5 video still owns");
    step(1, 0,0,1, 1, 1,1,  0,0,0, "R2 gnt off idle");
    step(1, 0,0,1, 0, 1,1,  0,0,1, "R4 audio after idle");
    step(1, 0,0,0, 1, 1,1,  1,0,0, "R1 quiet");
    // compatibility mode
    step(1, 1,1,1, 1, 1,1,  0,0,0, "R6 both before gnt");
    step(1, 1,1,0, 1, 1,1,  0,0,0, "R6 video before gnt");
    step(1, 1,1,0, 0, 1,1,  0,1,0, "R7 lock video");
    step(1, 1,0,1, 1, 0,1,  1,0,0, "R8 req drops with frame");
    step(1, 1,0,1, 1, 0,0,  1,0,0, "R7 audio masked");
    step(1, 1,0,1, 1, 1,0,  1,0,0, "R7 audio masked last phase");
    step(1, 1,0,1, 1, 1,1,  1,0,0, "R9 held through idle cycle");
    step(1, 1,0,1, 1, 1,1,  0,0,0, "R9 released to OR");
    step(1, 1,0,1, 0, 1,1,  0,0,1, "R7 lock audio");
    step(1, 1,1,0, 0, 1,1,  1,0,1, "R7 steering frozen on audio");
    step(1, 1,1,0, 1, 1,1,  1,0,0, "R10 withdrawn still locked");
    step(1, 1,1,0, 1, 1,1,  0,0,0, "R10 released after withdraw");
    step(1, 0,0,0, 1, 1,1,  1,0,0, "R1 final quiet");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule